// File: doc/BRIEF.md
# Shader Operand Router

This block is the operand-routing stage in front of a four-lane shader ALU. Each lane holds a 24-bit float. For every instruction it resolves up to three source register indices into vectors. The indices can land in an input bank, a temporary bank or a float uniform bank, and the first or second index can be shifted by an address register. It then reorders the lanes of each vector through a per-source selector and flips signs through a per-source negate flag, and presents the results combinationally as `op_a`, `op_b` and `op_c`.

The external ALU returns its vector on `result`. When `issue` is high, the block commits that vector into an output or temporary register, lane by lane under a write mask. The arithmetic itself is outside the block.

Input and uniform banks are loaded through simple write ports. Output registers are read back through `out_sel` and `out_vec`. Temporaries are observed through the source path.

Top module: `shader_operand_router`

## Requirements
- R1: Each source has an 8-bit selector. Operand lane i, located at bits [24i+23:24i], takes the source lane whose number is in selector bits [2i+1:2i].
- R2: A set negate flag inverts bit 23 of all four operand lanes. The flip is applied after the lane reorder.
- R3: Write mask bit i enables destination lane i. A lane whose bit is clear keeps its previous value.
- R4: `addr_sel` picks the index offset: 1 selects `addr0`, 2 selects `addr1`, and 0 or 3 select no offset. The offset is the low 7 bits of the chosen register, and it is added modulo 128.
- R5: In the two-source form the offset is added to the first source index when `inverted` is 0, and to the second source index when `inverted` is 1. The other index is used unchanged.
- R6: Source index map: 0x00–0x0F reads input register n, 0x10–0x1F reads temporary n-0x10, and 0x20–0x5F reads uniform n-0x20. Indices 0x60–0x7F read as all zeros.
- R7: A destination index below 0x10 writes output register n, and 0x10–0x1F writes temporary n-0x10. An index of 0x20 or above changes no register.
- R8: With `mad_form` set, `op_c` carries the third source with its own selector and negate flag, and no address offset is applied to any source. With `mad_form` clear, `op_c` is zero.
- R9: With `dot3` set, lane 3 of the destination is never written, whatever the mask says.
- R10: A write issued in one cycle is visible on `out_vec` and on the operand ports from the next cycle. Operand ports respond combinationally to their index and selector inputs.
- R11: Reset clears every bank to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_we | input | 1 | Input bank write enable |
| in_addr | input | 4 | Input bank write index |
| in_data | input | 96 | Input bank write vector |
| unif_we | input | 1 | Uniform bank write enable |
| unif_addr | input | 6 | Uniform bank write index |
| unif_data | input | 96 | Uniform bank write vector |
| addr0 | input | 8 | Address register 0 |
| addr1 | input | 8 | Address register 1 |
| addr_sel | input | 2 | Offset source select |
| mad_form | input | 1 | Three-source form |
| inverted | input | 1 | Inverted operand form |
| dot3 | input | 1 | Suppress lane 3 write |
| src1_idx | input | 7 | First source index |
| src2_idx | input | 7 | Second source index |
| src3_idx | input | 7 | Third source index |
| sel1 | input | 8 | First source lane selectors |
| sel2 | input | 8 | Second source lane selectors |
| sel3 | input | 8 | Third source lane selectors |
| neg1 | input | 1 | First source negate |
| neg2 | input | 1 | Second source negate |
| neg3 | input | 1 | Third source negate |
| issue | input | 1 | Commit strobe |
| dst_idx | input | 7 | Destination index |
| wmask | input | 4 | Destination lane mask |
| result | input | 96 | ALU result vector |
| op_a | output | 96 | First operand |
| op_b | output | 96 | Second operand |
| op_c | output | 96 | Third operand |
| out_sel | input | 4 | Output register read index |
| out_vec | output | 96 | Output register read data |

## Verification
Some properties are checked on every cycle. These are:
- an empty mask or a discarded destination leaves the observed output register unchanged;
- a full-mask write lands intact on the next cycle;
- the dot3 form preserves lane 3;
- `op_c` stays zero outside the three-source form;
- two identical sources differ only by the sign bits their negate flags imply.

Other behaviour can only be shown by the bench scenarios, because it depends on known bank contents. That covers the actual selector permutations, the index map into each bank, which source the offset moves in each form, offset wraparound, and partial-mask merges into temporaries.

// File: rtl/shader_operand_router.sv
module shader_operand_router #(
  parameter int LANE_W   = 24,
  parameter int NUM_REGS = 16,
  parameter int NUM_UNIF = 64,
  parameter int IDX_W    = 7,
  parameter int OFS_W    = 8
)(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_we,
  input  logic [$clog2(NUM_REGS)-1:0]  in_addr,
  input  logic [4*LANE_W-1:0]          in_data,
  input  logic                         unif_we,
  input  logic [$clog2(NUM_UNIF)-1:0]  unif_addr,
  input  logic [4*LANE_W-1:0]          unif_data,
  input  logic [OFS_W-1:0]             addr0,
  input  logic [OFS_W-1:0]             addr1,
  input  logic [1:0]                   addr_sel,
  input  logic                         mad_form,
  input  logic                         inverted,
  input  logic                         dot3,
  input  logic [IDX_W-1:0]             src1_idx,
  input  logic [IDX_W-1:0]             src2_idx,
  input  logic [IDX_W-1:0]             src3_idx,
  input  logic [7:0]                   sel1,
  input  logic [7:0]                   sel2,
  input  logic [7:0]                   sel3,
  input  logic                         neg1,
  input  logic                         neg2,
  input  logic                         neg3,
  input  logic                         issue,
  input  logic [IDX_W-1:0]             dst_idx,
  input  logic [3:0]                   wmask,
  input  logic [4*LANE_W-1:0]          result,
  output logic [4*LANE_W-1:0]          op_a,
  output logic [4*LANE_W-1:0]          op_b,
  output logic [4*LANE_W-1:0]          op_c,
  input  logic [$clog2(NUM_REGS)-1:0]  out_sel,
  output logic [4*LANE_W-1:0]          out_vec
);
  localparam int VW       = 4 * LANE_W;
  localparam int RW       = $clog2(NUM_REGS);
  localparam int UW       = $clog2(NUM_UNIF);
  localparam int TMP_BASE = NUM_REGS;
  localparam int UNI_BASE = 2 * NUM_REGS;
  localparam int UNI_END  = UNI_BASE + NUM_UNIF;

  logic [VW-1:0] in_bank  [NUM_REGS];
  logic [VW-1:0] tmp_bank [NUM_REGS];
  logic [VW-1:0] out_bank [NUM_REGS];
  logic [VW-1:0] uni_bank [NUM_UNIF];

  function automatic logic [VW-1:0] fetch(input logic [IDX_W-1:0] ix);
    int n;
    n = int'(ix);
    fetch = '0;
    if (n < TMP_BASE)      fetch = in_bank[RW'(n)];
    else if (n < UNI_BASE) fetch = tmp_bank[RW'(n - TMP_BASE)];
    else if (n < UNI_END)  fetch = uni_bank[UW'(n - UNI_BASE)];
  endfunction

  function automatic logic [VW-1:0] swz(input logic [VW-1:0] v, input logic [7:0] s,
                                        input logic ng);
    logic [VW-1:0] r;
    for (int i = 0; i < 4; i++) begin
      r[i*LANE_W +: LANE_W] = v[int'(s[2*i +: 2])*LANE_W +: LANE_W];
      r[i*LANE_W + LANE_W - 1] = r[i*LANE_W + LANE_W - 1] ^ ng;
    end
    return r;
  endfunction

  logic [IDX_W-1:0] ofs, e1, e2;
  logic [3:0]       lane_en;

  assign ofs = (addr_sel == 2'd1) ? addr0[IDX_W-1:0] :
               (addr_sel == 2'd2) ? addr1[IDX_W-1:0] : '0;
  assign e1  = src1_idx + ((!mad_form && !inverted) ? ofs : '0);
  assign e2  = src2_idx + ((!mad_form &&  inverted) ? ofs : '0);

  assign op_a    = swz(fetch(e1), sel1, neg1);
  assign op_b    = swz(fetch(e2), sel2, neg2);
  assign op_c    = mad_form ? swz(fetch(src3_idx), sel3, neg3) : '0;
  assign out_vec = out_bank[out_sel];
  assign lane_en = wmask & {~dot3, 3'b111};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_REGS; k++) begin
        in_bank[k]  <= '0;
        tmp_bank[k] <= '0;
        out_bank[k] <= '0;
      end
      for (int k = 0; k < NUM_UNIF; k++) uni_bank[k] <= '0;
    end else begin
      if (in_we)   in_bank[in_addr]    <= in_data;
      if (unif_we) uni_bank[unif_addr] <= unif_data;
      if (issue) begin
        for (int i = 0; i < 4; i++) begin
          if (lane_en[i]) begin
            if (int'(dst_idx) < TMP_BASE)
              out_bank[dst_idx[RW-1:0]][i*LANE_W +: LANE_W] <= result[i*LANE_W +: LANE_W];
            else if (int'(dst_idx) < UNI_BASE)
              tmp_bank[dst_idx[RW-1:0]][i*LANE_W +: LANE_W] <= result[i*LANE_W +: LANE_W];
          end
        end
      end
    end
  end
endmodule

// File: rtl/router_checker.sv
module router_checker #(
  parameter int LANE_W   = 24,
  parameter int IDX_W    = 7,
  parameter int RW       = 4,
  parameter int NUM_REGS = 16
)(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 issue,
  input logic [IDX_W-1:0]     dst_idx,
  input logic [3:0]           wmask,
  input logic                 dot3,
  input logic [4*LANE_W-1:0]  result,
  input logic [RW-1:0]        out_sel,
  input logic [4*LANE_W-1:0]  out_vec,
  input logic                 mad_form,
  input logic [1:0]           addr_sel,
  input logic [IDX_W-1:0]     src1_idx,
  input logic [IDX_W-1:0]     src2_idx,
  input logic [7:0]           sel1,
  input logic [7:0]           sel2,
  input logic                 neg1,
  input logic                 neg2,
  input logic [4*LANE_W-1:0]  op_a,
  input logic [4*LANE_W-1:0]  op_b,
  input logic [4*LANE_W-1:0]  op_c
);
  a_r3_empty_mask_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && wmask == 4'h0) |=> (out_sel != $past(out_sel)) || (out_vec == $past(out_vec)));

  a_r7_non_output_dst_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && int'(dst_idx) >= NUM_REGS) |=> (out_sel != $past(out_sel)) || (out_vec == $past(out_vec)));

  a_r10_full_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && wmask == 4'hF && !dot3 && dst_idx == IDX_W'(out_sel))
      |=> (out_sel != $past(out_sel)) || (out_vec == $past(result)));

  a_r9_dot3_lane3_held: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && dot3 && dst_idx == IDX_W'(out_sel))
      |=> (out_sel != $past(out_sel)) ||
          (out_vec[4*LANE_W-1 -: LANE_W] == $past(out_vec[4*LANE_W-1 -: LANE_W])));

  a_r8_third_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !mad_form |-> (op_c == '0));

  a_r2_sign_only_diff: assert property (@(posedge clk) disable iff (!rst_n)
    (!mad_form && addr_sel == 2'd0 && src1_idx == src2_idx && sel1 == sel2)
      |-> (op_b == (op_a ^ {4{{neg1 ^ neg2, {(LANE_W-1){1'b0}}}}})));
endmodule

bind shader_operand_router router_checker #(
  .LANE_W(LANE_W), .IDX_W(IDX_W), .RW($clog2(NUM_REGS)), .NUM_REGS(NUM_REGS)
) u_chk (.*);

// File: tb/tb_shader_operand_router.sv
module tb_shader_operand_router;
  localparam int VW = 96;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_we = 0, unif_we = 0, mad_form = 0, inverted = 0, dot3 = 0;
  logic neg1 = 0, neg2 = 0, neg3 = 0, issue = 0;
  logic [3:0] in_addr = 0, out_sel = 0, wmask = 0;
  logic [5:0] unif_addr = 0;
  logic [VW-1:0] in_data = 0, unif_data = 0, result = 0;
  logic [7:0] addr0 = 0, addr1 = 0, sel1 = 8'hE4, sel2 = 8'hE4, sel3 = 8'hE4;
  logic [1:0] addr_sel = 0;
  logic [6:0] src1_idx = 0, src2_idx = 0, src3_idx = 0, dst_idx = 0;
  logic [VW-1:0] op_a, op_b, op_c, out_vec;
  logic [VW-1:0] tmod [16];
  logic [VW-1:0] omod [16];
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  shader_operand_router dut (.*);

  function automatic logic [VW-1:0] mk(input logic [23:0] b);
    return {b + 24'd3, b + 24'd2, b + 24'd1, b};
  endfunction

  function automatic logic [VW-1:0] src_val(input int ix);
    if (ix < 16) return mk(24'h100000 + 24'(ix * 16));
    if (ix < 32) return tmod[ix - 16];
    if (ix < 96) return mk(24'h200000 + 24'((ix - 32) * 16));
    return '0;
  endfunction

  function automatic logic [VW-1:0] ew(input logic [VW-1:0] v, input logic [7:0] s, input logic ng);
    logic [VW-1:0] r;
    for (int i = 0; i < 4; i++) begin
      r[i*24 +: 24] = v[int'(s[2*i +: 2])*24 +: 24];
      if (ng) r[i*24 + 23] = ~r[i*24 + 23];
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] merge(input logic [VW-1:0] o, n, input logic [3:0] m);
    logic [VW-1:0] r;
    for (int i = 0; i < 4; i++) r[i*24 +: 24] = m[i] ? n[i*24 +: 24] : o[i*24 +: 24];
    return r;
  endfunction

  task automatic chk(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    issue = 0; mad_form = 0; inverted = 0; dot3 = 0; addr_sel = 0;
    neg1 = 0; neg2 = 0; neg3 = 0; sel1 = 8'hE4; sel2 = 8'hE4; sel3 = 8'hE4;
  endtask

  task automatic do_write(input logic [6:0] d, input logic [3:0] m, input logic dt,
                          input logic [VW-1:0] v);
    @(negedge clk);
    issue = 1; dst_idx = d; wmask = m; dot3 = dt; result = v;
    if (d < 16) out_sel = d[3:0];
    #1;
    if (d < 16) chk("R10 before commit", out_vec, omod[d]);
    @(negedge clk);
    issue = 0; dot3 = 0;
    if (d < 16) omod[d] = merge(omod[d], v, m & {~dt, 3'b111});
    else if (d < 32) tmod[d - 16] = merge(tmod[d - 16], v, m & {~dt, 3'b111});
  endtask

  task automatic t_reset();
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); out_sel = 4'(k); src1_idx = 7'(16 + k); #1;
      chk("R11 output bank", out_vec, '0);
      chk("R11 temp bank", op_a, '0);
    end
  endtask

  task automatic t_load();
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); in_we = 1; in_addr = 4'(k); in_data = mk(24'h100000 + 24'(k * 16));
    end
    for (int k = 0; k < 64; k++) begin
      @(negedge clk); in_we = 0; unif_we = 1; unif_addr = 6'(k);
      unif_data = mk(24'h200000 + 24'(k * 16));
    end
    @(negedge clk); unif_we = 0;
  endtask

  task automatic t_swizzle();
    @(negedge clk); idle(); src1_idx = 7'h03; src2_idx = 7'h25; #1;
    chk("R1 identity", op_a, src_val(3));
    chk("R6 uniform", op_b, src_val(7'h25));
    sel1 = 8'h1B; sel2 = 8'hAA; #1;
    chk("R1 reverse", op_a, ew(src_val(3), 8'h1B, 0));
    chk("R1 broadcast", op_b, ew(src_val(7'h25), 8'hAA, 0));
    src1_idx = 7'h60; src2_idx = 7'h7F; #1;
    chk("R6 zero type", op_a, '0);
    chk("R6 zero type top", op_b, '0);
    src1_idx = 7'h5F; #1;
    chk("R6 last uniform", op_a, ew(src_val(7'h5F), 8'h1B, 0));
  endtask

  task automatic t_negate();
    @(negedge clk); idle(); src1_idx = 7'h09; src2_idx = 7'h30;
    sel1 = 8'h4E; neg1 = 1; neg2 = 1; #1;
    chk("R2 negate swizzled", op_a, ew(src_val(9), 8'h4E, 1));
    chk("R2 negate plain", op_b, ew(src_val(7'h30), 8'hE4, 1));
  endtask

  task automatic t_offset();
    @(negedge clk); idle(); addr0 = 8'd5; addr1 = 8'hFE;
    addr_sel = 2'd1; src1_idx = 7'h02; src2_idx = 7'h21; #1;
    chk("R5 normal moves first", op_a, src_val(7));
    chk("R5 normal keeps second", op_b, src_val(7'h21));
    inverted = 1; #1;
    chk("R5 inverted keeps first", op_a, src_val(2));
    chk("R5 inverted moves second", op_b, src_val(7'h26));
    inverted = 0; addr_sel = 2'd2; src1_idx = 7'h22; #1;
    chk("R4 negative offset", op_a, src_val(7'h20));
    addr_sel = 2'd3; #1;
    chk("R4 select 3 none", op_a, src_val(7'h22));
    addr_sel = 2'd1; src1_idx = 7'h7F; #1;
    chk("R4 wrap", op_a, src_val(4));
  endtask

  task automatic t_write();
    idle();
    do_write(7'h02, 4'hF, 0, mk(24'h300000));
    out_sel = 2; #1; chk("R7 output write", out_vec, omod[2]);
    do_write(7'h02, 4'b0101, 0, mk(24'h400000));
    out_sel = 2; #1; chk("R3 partial mask", out_vec, omod[2]);
    do_write(7'h13, 4'b1011, 0, mk(24'h500000));
    src1_idx = 7'h13; #1; chk("R7 temp write R3", op_a, tmod[3]);
    do_write(7'h25, 4'hF, 0, mk(24'h600000));
    out_sel = 5; src1_idx = 7'h15; #1;
    chk("R7 discard output", out_vec, '0);
    chk("R7 discard temp", op_a, '0);
    do_write(7'h02, 4'h0, 0, mk(24'h650000));
    out_sel = 2; #1; chk("R3 empty mask", out_vec, omod[2]);
  endtask

  task automatic t_dot3();
    idle();
    do_write(7'h04, 4'hF, 0, mk(24'h700000));
    do_write(7'h04, 4'hF, 1, mk(24'h800000));
    out_sel = 4; #1;
    chk("R9 lane3 held", out_vec, {omod[4][95:72], mk(24'h800000)[71:0]});
    do_write(7'h14, 4'b1010, 1, mk(24'h900000));
    src1_idx = 7'h14; #1; chk("R9 temp lane1 only", op_a, tmod[4]);
  endtask

  task automatic t_mad();
    @(negedge clk); idle(); mad_form = 1; addr_sel = 2'd1; addr0 = 8'd5;
    src1_idx = 7'h02; src2_idx = 7'h23; src3_idx = 7'h13;
    sel3 = 8'h1B; neg3 = 1; neg1 = 1; #1;
    chk("R8 first no offset", op_a, ew(src_val(2), 8'hE4, 1));
    chk("R8 second", op_b, src_val(7'h23));
    chk("R8 third", op_c, ew(tmod[3], 8'h1B, 1));
    inverted = 1; #1;
    chk("R8 inverted no offset", op_b, src_val(7'h23));
    mad_form = 0; #1;
    chk("R8 third zero", op_c, '0);
  endtask

  initial begin
    for (int k = 0; k < 16; k++) begin tmod[k] = '0; omod[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_load();
    t_swizzle();
    t_negate();
    t_offset();
    t_write();
    t_dot3();
    t_mad();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule